// File: doc/BRIEF.md
# Power-on strap sampler with frequency select

This block holds the power-up configuration logic of a clock synthesizer that shares four package pads between configuration straps and clock outputs. When power-good rises, a window of a fixed number of reference-clock cycles begins. For the whole window the four pads stay in high impedance, so that external pull resistors set their levels. At the end of the window each pad level is captured once. The pads are then switched over to drive clocks. The captured bits stay fixed until power-good falls again.

Three of the captured bits and one dedicated band-select input form a 4-bit code. The code picks one of sixteen frequency rows for the CPU, 66 MHz, PCI and APIC clock groups. The fourth captured bit picks the Super I/O clock rate. Every frequency is given in kHz as an unsigned integer. There is no data stream, so every pin is a plain level signal and no back-pressure rules apply.

Top module: `strap_cfg_top`

## Requirements
- R1: From the rising edge of `pwr_good` through rising clock edge WIN_CYC, all four `pad_oe` bits and `config_valid` are low.
- R2: At rising edge WIN_CYC+1 after `pwr_good` rises, all four `pad_oe` bits and `config_valid` go high, and they stay high until `pwr_good` falls.
- R3: Each raw pad level passes through two synchronizing flops and is captured into `strap_q` at rising edge WIN_CYC. Index 0 is the SEL2 pad, 1 is the SEL1 pad, 2 is the SEL0/USB pad and 3 is the SIO pad.
- R4: Once captured, `strap_q` and the decoded outputs ignore any later change on `pad_in` until the next power cycle.
- R5: When `pwr_good` is low, `strap_q`, `pad_oe` and `config_valid` are cleared immediately, and the window restarts from zero on the next rise of `pwr_good`.
- R6: While `config_valid` is high, `freq_code` = {`sel_band`, `strap_q[0]`, `strap_q[1]`, `strap_q[2]`}, MSB first. `sel_band` is used live. While `config_valid` is low, `freq_code` is 0.
- R7: The code picks the CPU/66/PCI/APIC kHz values, for example: 4'b1111 gives 133300/66700/33300/16700, 4'b0111 gives 100200/66800/33400/16700, 4'b0011 gives 66800/66800/33400/16700, 4'b1000 gives 160000/80000/40000/20000. The other twelve rows follow the same sixteen-row table.
- R8: While `config_valid` is low, every kHz output is 0.
- R9: While `config_valid` is high, `sio_khz` is 24000 if `strap_q[3]` is 1 and 48000 if it is 0.
- R10: While `config_valid` is high, `usb_khz` is 48000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that times the window |
| pwr_good | input | 1 | Supply valid; low acts as asynchronous clear |
| pad_in | input | 4 | Raw levels of the four shared pads |
| sel_band | input | 1 | Dedicated band-select input, MSB of the code |
| pad_oe | output | 4 | Output enable for each shared pad |
| strap_q | output | 4 | Captured strap bits |
| freq_code | output | 4 | Frequency-select code |
| cpu_khz | output | 18 | CPU group frequency in kHz |
| bus66_khz | output | 18 | 66 MHz group frequency in kHz |
| pci_khz | output | 18 | PCI group frequency in kHz |
| apic_khz | output | 18 | APIC group frequency in kHz |
| sio_khz | output | 18 | Super I/O clock frequency in kHz |
| usb_khz | output | 18 | USB-rate pad frequency in kHz |
| config_valid | output | 1 | Straps captured and pads enabled |

## Verification
After `pwr_good` rises, the captured straps appear at rising edge WIN_CYC, and the enables, `config_valid` and the decoded frequencies appear one edge later at WIN_CYC+1. `freq_code` and the kHz outputs follow a change on `sel_band` in the same cycle, with no register in between. The bench always releases `pwr_good` half a period before a rising edge and counts edges from that point. It samples one time unit after the counted edge, so that a check made at edge WIN_CYC sees the straps captured and the enables still low, and a check made at edge WIN_CYC+1 sees the enables high. A clear through `pwr_good` is checked a short time after the fall, with no clock edge in between.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int KHZ_W    = 18;
  localparam int NPAD     = 4;
  localparam int PAD_SEL2 = 0;
  localparam int PAD_SEL1 = 1;
  localparam int PAD_SEL0 = 2;
  localparam int PAD_SIO  = 3;

  localparam logic [KHZ_W-1:0] SIO_FAST_KHZ = 18'd48000;
  localparam logic [KHZ_W-1:0] SIO_SLOW_KHZ = 18'd24000;
  localparam logic [KHZ_W-1:0] USB_KHZ      = 18'd48000;

  typedef logic [KHZ_W-1:0] khz_t;

  typedef struct packed {
    khz_t cpu;
    khz_t bus66;
    khz_t pci;
    khz_t apic;
  } freq_row_t;

  function automatic freq_row_t mk_row(input int c, input int b, input int p, input int a);
    freq_row_t r;
    r.cpu   = khz_t'(c);
    r.bus66 = khz_t'(b);
    r.pci   = khz_t'(p);
    r.apic  = khz_t'(a);
    return r;
  endfunction

  // code = {band, sel2, sel1, sel0}
  function automatic freq_row_t row_lookup(input logic [3:0] code);
    freq_row_t r;
    case (code)
      4'h0: r = mk_row(133900, 67000, 33500, 16700);
      4'h1: r = mk_row(128500, 64300, 32100, 16100);
      4'h2: r = mk_row(124000, 82700, 41300, 20700);
      4'h3: r = mk_row( 66800, 66800, 33400, 16700);
      4'h4: r = mk_row(120000, 80000, 40000, 20000);
      4'h5: r = mk_row(114000, 76000, 38000, 19000);
      4'h6: r = mk_row(105000, 70000, 35000, 17500);
      4'h7: r = mk_row(100200, 66800, 33400, 16700);
      4'h8: r = mk_row(160000, 80000, 40000, 20000);
      4'h9: r = mk_row(155000, 77500, 38800, 19400);
      4'hA: r = mk_row(152500, 76300, 38100, 19100);
      4'hB: r = mk_row(150000, 75000, 37500, 18800);
      4'hC: r = mk_row(148000, 74000, 37000, 18500);
      4'hD: r = mk_row(143000, 71500, 35800, 17900);
      4'hE: r = mk_row(138000, 69000, 34500, 17300);
      default: r = mk_row(133300, 66700, 33300, 16700);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_raw,
  output logic [N-1:0] d_sync
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_raw[g];
        s2 <= s1;
      end
    end
    assign d_sync[g] = s2;
  end
endmodule

// File: rtl/strap_window.sv
module strap_window #(
  parameter int WIN = 28636,
  parameter int N   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_sync,
  output logic [N-1:0] strap,
  output logic         oe
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt;
  logic          taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      taken <= 1'b0;
      strap <= '0;
      oe    <= 1'b0;
    end else begin
      if (!taken) begin
        if (cnt == LAST) begin
          taken <= 1'b1;
          strap <= d_sync;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      oe <= taken;
    end
  end
endmodule

// File: rtl/freq_decode.sv
module freq_decode
  import strap_cfg_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] code,
  input  logic       sio_bit,
  output khz_t       cpu_khz,
  output khz_t       bus66_khz,
  output khz_t       pci_khz,
  output khz_t       apic_khz,
  output khz_t       sio_khz,
  output khz_t       usb_khz
);
  freq_row_t row;

  always_comb begin
    row = row_lookup(code);
    if (valid) begin
      cpu_khz   = row.cpu;
      bus66_khz = row.bus66;
      pci_khz   = row.pci;
      apic_khz  = row.apic;
      sio_khz   = sio_bit ? SIO_SLOW_KHZ : SIO_FAST_KHZ;
      usb_khz   = USB_KHZ;
    end else begin
      cpu_khz   = '0;
      bus66_khz = '0;
      pci_khz   = '0;
      apic_khz  = '0;
      sio_khz   = '0;
      usb_khz   = '0;
    end
  end
endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_cfg_pkg::*;
#(
  parameter int WIN = 28636
) (
  input  logic        clk_ref,
  input  logic        pwr_good,
  input  logic [3:0]  pad_in,
  input  logic        sel_band,
  output logic [3:0]  pad_oe,
  output logic [3:0]  strap_q,
  output logic [3:0]  freq_code,
  output logic [17:0] cpu_khz,
  output logic [17:0] bus66_khz,
  output logic [17:0] pci_khz,
  output logic [17:0] apic_khz,
  output logic [17:0] sio_khz,
  output logic [17:0] usb_khz,
  output logic        config_valid
);
  logic [NPAD-1:0] pad_sync;
  logic            oe_on;

  strap_sync #(.N(NPAD)) u_sync (
    .clk    (clk_ref),
    .rst_n  (pwr_good),
    .d_raw  (pad_in),
    .d_sync (pad_sync)
  );

  strap_window #(.WIN(WIN), .N(NPAD)) u_win (
    .clk    (clk_ref),
    .rst_n  (pwr_good),
    .d_sync (pad_sync),
    .strap  (strap_q),
    .oe     (oe_on)
  );

  assign pad_oe       = {NPAD{oe_on}};
  assign config_valid = oe_on;
  assign freq_code    = oe_on ? {sel_band, strap_q[PAD_SEL2], strap_q[PAD_SEL1], strap_q[PAD_SEL0]}
                              : 4'b0000;

  freq_decode u_dec (
    .valid     (oe_on),
    .code      (freq_code),
    .sio_bit   (strap_q[PAD_SIO]),
    .cpu_khz   (cpu_khz),
    .bus66_khz (bus66_khz),
    .pci_khz   (pci_khz),
    .apic_khz  (apic_khz),
    .sio_khz   (sio_khz),
    .usb_khz   (usb_khz)
  );
endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk #(
  parameter int WIN = 28636
) (
  input logic        clk_ref,
  input logic        pwr_good,
  input logic [3:0]  pad_in,
  input logic        sel_band,
  input logic [3:0]  pad_oe,
  input logic [3:0]  strap_q,
  input logic [3:0]  freq_code,
  input logic [17:0] cpu_khz,
  input logic [17:0] bus66_khz,
  input logic [17:0] pci_khz,
  input logic [17:0] apic_khz,
  input logic [17:0] sio_khz,
  input logic [17:0] usb_khz,
  input logic        config_valid
);
  logic [31:0] ccnt;
  logic        pad_seen;

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) ccnt <= '0;
    else if (ccnt < 32'(WIN + 2)) ccnt <= ccnt + 1'b1;
  end

  assign pad_seen = ^pad_in;

  assert_oe_low_in_window_R1: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    (ccnt <= 32'(WIN)) |-> (pad_oe == 4'b0000 && !config_valid));

  assert_oe_high_after_R2: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    (ccnt > 32'(WIN)) |-> (pad_oe == 4'b1111 && config_valid));

  assert_strap_frozen_R4: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    (config_valid && (pad_seen || !pad_seen)) |=> $stable(strap_q));

  assert_code_form_R6: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    config_valid |-> (freq_code == {sel_band, strap_q[0], strap_q[1], strap_q[2]}));

  assert_zero_when_idle_R8: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    !config_valid |-> (cpu_khz == 0 && bus66_khz == 0 && pci_khz == 0 && apic_khz == 0
                       && sio_khz == 0 && usb_khz == 0));

  assert_sio_rate_R9: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    config_valid |-> (sio_khz == (strap_q[3] ? 18'd24000 : 18'd48000)));

  assert_usb_rate_R10: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    config_valid |-> (usb_khz == 18'd48000));
endmodule

bind strap_cfg_top strap_cfg_chk #(.WIN(WIN)) u_chk (
  .clk_ref      (clk_ref),
  .pwr_good     (pwr_good),
  .pad_in       (pad_in),
  .sel_band     (sel_band),
  .pad_oe       (pad_oe),
  .strap_q      (strap_q),
  .freq_code    (freq_code),
  .cpu_khz      (cpu_khz),
  .bus66_khz    (bus66_khz),
  .pci_khz      (pci_khz),
  .apic_khz     (apic_khz),
  .sio_khz      (sio_khz),
  .usb_khz      (usb_khz),
  .config_valid (config_valid)
);

// File: tb/sim_strap_cfg_top.sv
`timescale 1ns/1ps
module sim_strap_cfg_top;
  localparam int WIN = 40;

  logic        clk_ref = 1'b0;
  logic        pwr_good = 1'b0;
  logic [3:0]  pad_in = 4'b0000;
  logic        sel_band = 1'b0;
  logic [3:0]  pad_oe, strap_q, freq_code;
  logic [17:0] cpu_khz, bus66_khz, pci_khz, apic_khz, sio_khz, usb_khz;
  logic        config_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_ref = ~clk_ref;

  strap_cfg_top #(.WIN(WIN)) u0 (
    .clk_ref(clk_ref), .pwr_good(pwr_good), .pad_in(pad_in), .sel_band(sel_band),
    .pad_oe(pad_oe), .strap_q(strap_q), .freq_code(freq_code),
    .cpu_khz(cpu_khz), .bus66_khz(bus66_khz), .pci_khz(pci_khz), .apic_khz(apic_khz),
    .sio_khz(sio_khz), .usb_khz(usb_khz), .config_valid(config_valid)
  );

  // {code, cpu, bus66, pci, apic}
  localparam bit [75:0] VEC [0:15] = '{
    {4'hF, 18'd133300, 18'd66700, 18'd33300, 18'd16700},
    {4'h7, 18'd100200, 18'd66800, 18'd33400, 18'd16700},
    {4'h3, 18'd66800,  18'd66800, 18'd33400, 18'd16700},
    {4'h8, 18'd160000, 18'd80000, 18'd40000, 18'd20000},
    {4'h0, 18'd133900, 18'd67000, 18'd33500, 18'd16700},
    {4'h1, 18'd128500, 18'd64300, 18'd32100, 18'd16100},
    {4'h2, 18'd124000, 18'd82700, 18'd41300, 18'd20700},
    {4'h4, 18'd120000, 18'd80000, 18'd40000, 18'd20000},
    {4'h5, 18'd114000, 18'd76000, 18'd38000, 18'd19000},
    {4'h6, 18'd105000, 18'd70000, 18'd35000, 18'd17500},
    {4'h9, 18'd155000, 18'd77500, 18'd38800, 18'd19400},
    {4'hA, 18'd152500, 18'd76300, 18'd38100, 18'd19100},
    {4'hB, 18'd150000, 18'd75000, 18'd37500, 18'd18800},
    {4'hC, 18'd148000, 18'd74000, 18'd37000, 18'd18500},
    {4'hD, 18'd143000, 18'd71500, 18'd35800, 18'd17900},
    {4'hE, 18'd138000, 18'd69000, 18'd34500, 18'd17300}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_ref);
    #1;
  endtask

  // pads: [0]=SEL2, [1]=SEL1, [2]=SEL0, [3]=SIO
  task automatic power_up(input logic [3:0] code, input logic sio);
    @(negedge clk_ref);
    pwr_good = 1'b0;
    #1;
    pad_in   = {sio, code[0], code[1], code[2]};
    sel_band = code[3];
    @(negedge clk_ref);
    pwr_good = 1'b1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset state
    edges(3);
    chk("R5 reset oe", 32'(pad_oe), 0);
    chk("R5 reset strap", 32'(strap_q), 0);
    chk("R5 reset valid", 32'(config_valid), 0);
    chk("R8 reset cpu", 32'(cpu_khz), 0);

    for (int i = 0; i < 16; i++) begin
      logic [3:0] code;
      logic sio;
      code = VEC[i][75:72];
      sio  = ~code[1];
      power_up(code, sio);
      edges(WIN);
      chk("R1 oe low at window end", 32'(pad_oe), 0);
      chk("R1 valid low at window end", 32'(config_valid), 0);
      chk("R8 cpu zero in window", 32'(cpu_khz), 0);
      chk("R3 strap captured", 32'(strap_q), 32'({sio, code[0], code[1], code[2]}));
      edges(1);
      chk("R2 oe high", 32'(pad_oe), 32'hF);
      chk("R2 valid high", 32'(config_valid), 1);
      chk("R6 code", 32'(freq_code), 32'(code));
      chk("R7 cpu", 32'(cpu_khz), 32'(VEC[i][71:54]));
      chk("R7 bus66", 32'(bus66_khz), 32'(VEC[i][53:36]));
      chk("R7 pci", 32'(pci_khz), 32'(VEC[i][35:18]));
      chk("R7 apic", 32'(apic_khz), 32'(VEC[i][17:0]));
      chk("R9 sio", 32'(sio_khz), sio ? 32'd24000 : 32'd48000);
      chk("R10 usb", 32'(usb_khz), 32'd48000);
    end

    // R4: pad changes after capture are ignored (last code 4'hE, sio=0)
    pad_in = ~pad_in;
    edges(6);
    chk("R4 strap held", 32'(strap_q), 32'(4'b0011));
    chk("R4 cpu held", 32'(cpu_khz), 32'd138000);
    chk("R4 sio held", 32'(sio_khz), 32'd48000);

    // R6: live band select, 4'hE -> 4'h6
    sel_band = 1'b0;
    #1;
    chk("R6 live band code", 32'(freq_code), 32'h6);
    chk("R7 live band cpu", 32'(cpu_khz), 32'd105000);

    // R5: drop mid-window restarts the count
    power_up(4'hF, 1'b1);
    edges(WIN / 2);
    pwr_good = 1'b0;
    #1;
    chk("R5 clear strap", 32'(strap_q), 0);
    chk("R8 clear cpu", 32'(cpu_khz), 0);
    @(negedge clk_ref);
    pwr_good = 1'b1;
    edges(WIN - 1);
    chk("R5 restart strap not yet", 32'(strap_q), 0);
    chk("R5 restart oe low", 32'(pad_oe), 0);
    edges(1);
    chk("R3 restart capture", 32'(strap_q), 32'hF);
    edges(1);
    chk("R2 restart valid", 32'(config_valid), 1);
    chk("R7 restart cpu", 32'(cpu_khz), 32'd133300);
    pwr_good = 1'b0;
    #1;
    chk("R5 async clear oe", 32'(pad_oe), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule